// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the status byte that a flash array returns to the host while an internal program or erase is running, waiting to start, or suspended. The surrounding controller tells it which operation is in flight, its phase, the most significant bit of the byte being written, and which sectors are marked for erase. The read path supplies the sector of the current address and a read strobe. The block answers with an 8-bit status word and a select line. The select line tells the read multiplexer whether to return this word or ordinary array data.

Two bits carry toggle state. One bit flips on every completed status read while an operation is in flight. The other bit flips only when the read address falls in a sector chosen for erase. A host can therefore tell a running operation from an idle one, and an erasing or suspended sector from an untouched one, without any other register. Each read counts when the strobe is released. A pulse on the start input clears both toggle bits before a new operation.

Top module: `embop_status_gen`

## Requirements
- R1: After reset both toggle bits are 0, and with the phase idle (0) the select output is low and the status word is 8'h00.
- R2: In the running phase (2) of a program (erase flag low), bit 7 of the status reads as the inverse of the programmed data's most significant bit, and bits 3 and 2 read 0.
- R3: For an erase, bit 7 reads 0 in the collection phase (1) and in the running phase (2), and reads 1 in the suspended phase (3).
- R4: Bit 6 inverts once per read (strobe falling) in the collection and running phases, whatever the read sector is. It keeps its value in the suspended and idle phases.
- R5: Bit 2 inverts once per read during an erase (phases 1, 2 or 3) only when the read sector is set in the erase selection mask. Otherwise it keeps its value, and it never moves during a program.
- R6: For an erase, bit 3 reads 0 in the collection phase and 1 in the running and suspended phases.
- R7: Bit 5 equals the timeout input in the running phase and reads 0 in every other phase.
- R8: The select output is high in the collection and running phases. In the suspended phase it is high only for a read sector that is set in the erase mask. It is low when idle.
- R9: A pulse on the start input clears both toggle bits at the next clock edge, taking priority over a read ending in the same cycle.
- R10: Bits 4, 1 and 0 always read 0, and the whole status word is 8'h00 whenever the select output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse marking the start of a new operation |
| op_phase | input | 2 | 0 idle, 1 erase collection window, 2 running, 3 erase suspended |
| op_is_erase | input | 1 | 1 for erase, 0 for program |
| prog_data_msb | input | 1 | Most significant bit of the byte being programmed |
| sel_mask | input | NSECT | One bit per sector selected for erase |
| rd_sector | input | SECW | Sector index of the current read address |
| rd_stb | input | 1 | Read strobe, high for the duration of a read |
| op_timeout | input | 1 | Internal pulse-count limit exceeded |
| show_status | output | 1 | High when the read returns the status word instead of array data |
| status | output | 8 | Status word |

## Verification
The hardest state to reach is a toggle pair that has drifted apart: bit 6 and bit 2 hold different values and must each follow their own rule across a phase change. The bench gets there with a run of reads that alternates between a selected and an unselected sector during a running erase. That run advances bit 6 alone on some reads. The bench then moves to the suspended phase and reads again in both sectors. Bit 2 must keep moving in the selected sector while bit 6 stays frozen and the select output drops for the other sector. A final start pulse, given while a read is ending, must clear both bits at once.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_RUN     = 2'd2,
    PH_SUSP    = 2'd3
  } phase_t;

  localparam int unsigned STW      = 8;
  localparam int unsigned B_POLL   = 7;
  localparam int unsigned B_TOGGLE = 6;
  localparam int unsigned B_LIMIT  = 5;
  localparam int unsigned B_STARTD = 3;
  localparam int unsigned B_SECTOG = 2;
endpackage

// File: rtl/esg_strobe_edge.sv
module esg_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign fall = stb_q & ~stb;
endmodule

// File: rtl/esg_sector_hit.sv
module esg_sector_hit #(
  parameter int unsigned NSECT = 8,
  localparam int unsigned SECW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic [NSECT-1:0] mask,
  input  logic [SECW-1:0]  sector,
  output logic             hit
);
  logic [NSECT-1:0] match;

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    assign match[i] = mask[i] && (sector == SECW'(i));
  end

  assign hit = |match;
endmodule

// File: rtl/esg_toggle_pair.sv
module esg_toggle_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv_op,
  input  logic adv_sec,
  output logic tog_op,
  output logic tog_sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_op  <= 1'b0;
      tog_sec <= 1'b0;
    end else if (clr) begin
      tog_op  <= 1'b0;
      tog_sec <= 1'b0;
    end else begin
      if (adv_op)  tog_op  <= ~tog_op;
      if (adv_sec) tog_sec <= ~tog_sec;
    end
  end
endmodule

// File: rtl/esg_status_pack.sv
module esg_status_pack
  import esg_pkg::*;
(
  input  phase_t          ph,
  input  logic            is_erase,
  input  logic            data_msb,
  input  logic            timeout,
  input  logic            tog_op,
  input  logic            tog_sec,
  input  logic            show,
  output logic [STW-1:0]  word
);
  always_comb begin
    word = '0;
    if (show) begin
      if (ph == PH_SUSP)  word[B_POLL] = 1'b1;
      else if (is_erase)  word[B_POLL] = 1'b0;
      else                word[B_POLL] = ~data_msb;
      word[B_TOGGLE] = tog_op;
      word[B_LIMIT]  = timeout && (ph == PH_RUN);
      word[B_STARTD] = is_erase && (ph == PH_RUN || ph == PH_SUSP);
      word[B_SECTOG] = tog_sec;
    end
  end
endmodule

// File: rtl/embop_status_gen.sv
module embop_status_gen #(
  parameter int unsigned NSECT = 8,
  localparam int unsigned SECW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [1:0]       op_phase,
  input  logic             op_is_erase,
  input  logic             prog_data_msb,
  input  logic [NSECT-1:0] sel_mask,
  input  logic [SECW-1:0]  rd_sector,
  input  logic             rd_stb,
  input  logic             op_timeout,
  output logic             show_status,
  output logic [7:0]       status
);
  import esg_pkg::*;

  phase_t ph;
  logic   rd_fall, sel_hit, in_flight, erase_live;
  logic   adv_op, adv_sec, tog_op, tog_sec;

  assign ph         = phase_t'(op_phase);
  assign in_flight  = (ph == PH_RUN) || (ph == PH_COLLECT);
  assign erase_live = op_is_erase && (ph != PH_IDLE);

  esg_strobe_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (rd_stb),
    .fall (rd_fall)
  );

  esg_sector_hit #(.NSECT(NSECT)) u_hit (
    .mask  (sel_mask),
    .sector(rd_sector),
    .hit   (sel_hit)
  );

  assign show_status = in_flight || ((ph == PH_SUSP) && sel_hit);
  assign adv_op      = rd_fall && in_flight;
  assign adv_sec     = rd_fall && erase_live && sel_hit;

  esg_toggle_pair u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (op_start),
    .adv_op (adv_op),
    .adv_sec(adv_sec),
    .tog_op (tog_op),
    .tog_sec(tog_sec)
  );

  esg_status_pack u_pack (
    .ph      (ph),
    .is_erase(op_is_erase),
    .data_msb(prog_data_msb),
    .timeout (op_timeout),
    .tog_op  (tog_op),
    .tog_sec (tog_sec),
    .show    (show_status),
    .word    (status)
  );
endmodule

// File: rtl/embop_status_gen_chk.sv
module embop_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic [1:0] op_phase,
  input logic       op_is_erase,
  input logic       prog_data_msb,
  input logic       rd_stb,
  input logic       show_status,
  input logic [7:0] status
);
  AST_QUIET_WHEN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !show_status |-> (status == 8'h00)); // R10

  AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == 2'd2 && !op_is_erase) |-> (status[7] == !prog_data_msb)); // R2

  AST_RUN_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_stb) && op_phase == 2'd2 && !op_start)
      |=> (op_phase != 2'd2 || status[6] != $past(status[6]))); // R4

  AST_SUSP_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == 2'd3 && show_status && !op_start)
      |=> (op_phase != 2'd3 || !show_status || $stable(status[6]))); // R4

  AST_COLLECT_NOT_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == 2'd1 && op_is_erase) |-> (show_status && !status[3])); // R6

  AST_IDLE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == 2'd0) |-> !show_status); // R8
endmodule

bind embop_status_gen embop_status_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_start     (op_start),
  .op_phase     (op_phase),
  .op_is_erase  (op_is_erase),
  .prog_data_msb(prog_data_msb),
  .rd_stb       (rd_stb),
  .show_status  (show_status),
  .status       (status)
);

// File: tb/test_embop_status_gen.sv
module test_embop_status_gen;
  localparam int unsigned NSECT = 8;
  localparam int unsigned SECW  = 3;
  localparam int NVEC = 12;

  // {phase[31:30], erase[29], msb[28], sel[27:20], sector[19:17], tmo[16], show[8], stat[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 7'd0, 1'b0, 8'h00}, // R8 R10 idle
    {2'd2, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 7'd0, 1'b1, 8'h00}, // R2 msb 1
    {2'd2, 1'b0, 1'b0, 8'hFF, 3'd1, 1'b0, 7'd0, 1'b1, 8'h80}, // R2 msb 0
    {2'd2, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 7'd0, 1'b1, 8'hA0}, // R7 program
    {2'd1, 1'b1, 1'b0, 8'h04, 3'd2, 1'b0, 7'd0, 1'b1, 8'h00}, // R3 R6 collect
    {2'd2, 1'b1, 1'b0, 8'h04, 3'd5, 1'b0, 7'd0, 1'b1, 8'h08}, // R3 R6 run
    {2'd2, 1'b1, 1'b1, 8'h04, 3'd5, 1'b1, 7'd0, 1'b1, 8'h28}, // R7 erase
    {2'd3, 1'b1, 1'b0, 8'h04, 3'd2, 1'b0, 7'd0, 1'b1, 8'h88}, // R3 R8 susp in
    {2'd3, 1'b1, 1'b0, 8'h04, 3'd5, 1'b0, 7'd0, 1'b0, 8'h00}, // R8 susp out
    {2'd3, 1'b1, 1'b0, 8'h04, 3'd2, 1'b1, 7'd0, 1'b1, 8'h88}, // R7 susp
    {2'd0, 1'b1, 1'b0, 8'hFF, 3'd7, 1'b1, 7'd0, 1'b0, 8'h00}, // R8 idle erase
    {2'd1, 1'b1, 1'b1, 8'hFF, 3'd7, 1'b1, 7'd0, 1'b1, 8'h00}  // R7 collect
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_start = 1'b0;
  logic [1:0]       op_phase = 2'd0;
  logic             op_is_erase = 1'b0;
  logic             prog_data_msb = 1'b0;
  logic [NSECT-1:0] sel_mask = '0;
  logic [SECW-1:0]  rd_sector = '0;
  logic             rd_stb = 1'b0;
  logic             op_timeout = 1'b0;
  logic             show_status;
  logic [7:0]       status;

  int checks = 0;
  int errors = 0;
  logic e6 = 1'b0;
  logic e2 = 1'b0;

  always #5 clk = ~clk;

  embop_status_gen #(.NSECT(NSECT)) i_embop_status_gen (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_phase(op_phase),
    .op_is_erase(op_is_erase), .prog_data_msb(prog_data_msb),
    .sel_mask(sel_mask), .rd_sector(rd_sector), .rd_stb(rd_stb),
    .op_timeout(op_timeout), .show_status(show_status), .status(status)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual show/status=%h expected=%h", req, act, exp);
    end
  endtask

  // one read: status sampled while strobe high, advance after release
  task automatic do_read(input logic [SECW-1:0] sec, input string req);
    logic [7:0] exp;
    logic       shw, in_fl, hit;
    @(negedge clk);
    rd_sector = sec;
    rd_stb = 1'b1;
    @(negedge clk);
    in_fl = (op_phase == 2'd1) || (op_phase == 2'd2);
    hit   = sel_mask[sec];
    shw   = in_fl || (op_phase == 2'd3 && hit);
    exp = 8'h00;
    if (shw) begin
      exp[7] = (op_phase == 2'd3) ? 1'b1 : (op_is_erase ? 1'b0 : ~prog_data_msb);
      exp[6] = e6;
      exp[5] = op_timeout && op_phase == 2'd2;
      exp[3] = op_is_erase && (op_phase == 2'd2 || op_phase == 2'd3);
      exp[2] = e2;
    end
    check(req, {show_status, status}, {shw, exp});
    rd_stb = 1'b0;
    if (in_fl) e6 = ~e6;
    if (op_is_erase && op_phase != 2'd0 && hit) e2 = ~e2;
    @(negedge clk);
  endtask

  task automatic start_op(input logic [1:0] ph, input logic er, input logic [7:0] msk);
    @(negedge clk);
    op_phase = ph; op_is_erase = er; sel_mask = msk; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    e6 = 1'b0; e2 = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {show_status, status}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // static decode table
    for (int i = 0; i < NVEC; i++) begin
      op_phase      = VEC[i][31:30];
      op_is_erase   = VEC[i][29];
      prog_data_msb = VEC[i][28];
      sel_mask      = VEC[i][27:20];
      rd_sector     = VEC[i][19:17];
      op_timeout    = VEC[i][16];
      @(negedge clk);
      check($sformatf("R2/R3/R6/R7/R8/R10 vector %0d", i),
            {show_status, status}, VEC[i][8:0]);
    end
    op_timeout = 1'b0;

    // running erase: sector 2 selected, sector 5 not
    start_op(2'd2, 1'b1, 8'h04);
    do_read(3'd2, "R4 R5 erase run sel");
    do_read(3'd2, "R4 R5 erase run sel");
    do_read(3'd5, "R4 R5 erase run unsel");
    do_read(3'd2, "R4 R5 erase run sel");
    do_read(3'd5, "R5 erase run unsel");

    // suspend: bit 6 frozen, bit 2 still moves in selected sector
    @(negedge clk); op_phase = 2'd3;
    do_read(3'd2, "R4 R5 susp sel");
    do_read(3'd2, "R4 R5 susp sel");
    do_read(3'd5, "R8 susp unsel array");
    do_read(3'd2, "R4 R5 susp sel after unsel");

    // resume then collect window also toggles
    @(negedge clk); op_phase = 2'd1;
    do_read(3'd6, "R4 R6 collect unsel");
    do_read(3'd2, "R5 collect sel");

    // start pulse coinciding with strobe release wins
    @(negedge clk); op_phase = 2'd2; rd_sector = 3'd2; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
    e6 = 1'b0; e2 = 1'b0;
    check("R9 clear on start", {show_status, status[6], status[2]}, {1'b1, 1'b0, 1'b0});
    do_read(3'd2, "R9 after clear");

    // program: sector toggle never moves even with mask set
    start_op(2'd2, 1'b0, 8'hFF);
    prog_data_msb = 1'b1;
    do_read(3'd3, "R5 program no sector toggle");
    do_read(3'd3, "R2 R5 program");
    @(negedge clk); op_phase = 2'd0;
    do_read(3'd3, "R4 idle hidden");
    @(negedge clk); op_phase = 2'd2;
    @(negedge clk);
    check("R4 idle read no advance", {show_status, status[6]}, {1'b1, e6});

    // reset mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    op_phase = 2'd0;
    @(negedge clk);
    check("R1 reset again", {show_status, status}, 9'h000);
    rst_n = 1'b1;
    op_phase = 2'd2;
    @(negedge clk);
    check("R1 toggles zero after reset", {show_status, status[6], status[2]}, {1'b1, 1'b0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule